// File: doc/BRIEF.md
# Floating-Point Operand Forwarding and Decode Stall Unit

This block resolves read-after-write hazards for the operands of a floating-point pipeline with decode, execute, memory and writeback stages. Each cycle it compares the three source register addresses of the instruction in execute against the destination register of the instruction in memory and the one in writeback. For each operand it then tells the forwarding multiplexer where to take the value from: the register file, the writeback result, or the memory-stage result.

Some result kinds are already complete in the memory stage: sign injection, compare, integer conversion and integer move. Fused multiply-add, divide/square root and format conversion between floating-point widths finish only at writeback. When an operand depends on a memory-stage instruction whose result is not yet available, the unit asks the front of the pipeline to stall decode. A later cycle then picks the value up from writeback. The unit is purely combinational and has no state.

Top module: `fp_fwd_hazard`

## Requirements
- R1: When no source address matches an enabled memory or writeback destination, every operand select is 0 (register file) and the stall output is 0.
- R2: An operand whose address equals the memory-stage destination while the memory write enable is 1 gets select 2 (memory result). If the memory result-select code is 4 (early result), the stall output is 0.
- R3: An operand that matches only the enabled writeback destination gets select 1 (writeback result).
- R4: When an operand matches both enabled destinations, the memory stage wins and the select is 2.
- R5: An address equal to the memory-stage destination is ignored while the memory write enable is 0. The select then falls to 1 on a writeback match and to 0 otherwise, and no stall is raised.
- R6: An address equal to the writeback destination is ignored while the writeback write enable is 0, giving select 0 when there is no memory match.
- R7: The stall output is 1 whenever at least one operand matches the enabled memory-stage destination and the memory result-select code is any value other than 4.
- R8: The three operands are resolved independently. Different operands may receive different selects in the same cycle.
- R9: Writeback matches never raise the stall output, whatever the memory result-select code.
- R10: The select value 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_x_addr | input | 5 | First source register address in execute |
| src_y_addr | input | 5 | Second source register address in execute |
| src_z_addr | input | 5 | Third source register address in execute |
| mem_wr_en | input | 1 | Memory-stage instruction writes an FP register |
| mem_dst_addr | input | 5 | Memory-stage destination register |
| mem_res_kind | input | 3 | Memory-stage result-select code; 4 means the result is ready in memory |
| wb_wr_en | input | 1 | Writeback-stage instruction writes an FP register |
| wb_dst_addr | input | 5 | Writeback-stage destination register |
| fwd_x_sel | output | 2 | Source for first operand: 0 regfile, 1 writeback, 2 memory |
| fwd_y_sel | output | 2 | Source for second operand, same encoding |
| fwd_z_sel | output | 2 | Source for third operand, same encoding |
| stall_dec | output | 1 | Stall decode: a memory-stage result is needed but not ready |

## Verification
On every evaluation, the assertions check several properties. A writeback select implies an enabled writeback match with no memory match. A memory select implies an enabled memory match. The select never takes the value 3. A stall implies a late result code and at least one operand selecting the memory stage. Only the bench's scenarios can show that each match actually produces the expected select. These scenarios also cover the priority when both stages hit the same register, the disabled write enables being ignored, and every result code from 0 to 7 against every combination of operand matches.

// File: rtl/fp_fwd_hazard_pkg.sv
// Package: shared types for the FP forwarding/stall unit.
// Assumes a 2-bit select consumed by a three-input forwarding mux.
package fp_fwd_hazard_pkg;
    typedef enum logic [1:0] {
        FWD_REGFILE = 2'd0,
        FWD_WB      = 2'd1,
        FWD_MEM     = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/fp_operand_fwd.sv
// Module: fp_operand_fwd
// Resolves one operand: compares its address against the memory and
// writeback destinations and picks the youngest enabled producer.
// Assumes addresses are stable for the whole evaluation; purely combinational.
module fp_operand_fwd
    import fp_fwd_hazard_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_dst_addr,
    input  logic              wb_wr_en,
    input  logic [ADDR_W-1:0] wb_dst_addr,
    output fwd_sel_e          sel,
    output logic              mem_hit
);
    logic wb_hit;

    // Qualified address matches for each producing stage.
    always_comb begin
        mem_hit = mem_wr_en && (src_addr == mem_dst_addr);
        wb_hit  = wb_wr_en  && (src_addr == wb_dst_addr);
    end

    // Priority pick: the younger (memory) producer wins over writeback.
    always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_REGFILE;
    end

    // Checks on the select against the raw port inputs.
    always_comb begin
        p_wb_sel_valid_r3: assert (sel != FWD_WB ||
            (wb_wr_en && src_addr == wb_dst_addr &&
             !(mem_wr_en && src_addr == mem_dst_addr)))
            else $error("writeback select without a sole writeback match");
        p_mem_sel_valid_r5: assert (sel != FWD_MEM ||
            (mem_wr_en && src_addr == mem_dst_addr))
            else $error("memory select without enabled memory match");
        p_no_code3_r10: assert (sel != 2'd3)
            else $error("reserved select value produced");
    end
endmodule

// File: rtl/fp_stall_detect.sv
// Module: fp_stall_detect
// Raises the decode stall when any operand depends on the memory stage
// and the memory-stage result kind is not one that completes in memory.
// Assumes mem_hit bits are already qualified by the write enable.
module fp_stall_detect #(
    parameter int NUM_SRC    = 3,
    parameter int KIND_W     = 3,
    parameter int EARLY_KIND = 4
) (
    input  logic [NUM_SRC-1:0] mem_hit,
    input  logic [KIND_W-1:0]  mem_res_kind,
    output logic               stall
);
    localparam logic [KIND_W-1:0] EarlyCode = KIND_W'(EARLY_KIND);

    logic late_result;

    // Classify whether the memory-stage result is not yet forwardable.
    always_comb late_result = (mem_res_kind != EarlyCode);

    // Stall on any dependent operand facing a late result.
    always_comb stall = late_result && (|mem_hit);

    always_comb begin
        p_stall_late_only_r7: assert (!stall || mem_res_kind != EarlyCode)
            else $error("stall raised for an early result kind");
    end
endmodule

// File: rtl/fp_fwd_hazard.sv
// Module: fp_fwd_hazard (top)
// Three-operand forwarding select and decode stall for an FP pipeline.
// Assumes one instruction per stage; combinational, no reset needed.
module fp_fwd_hazard
    import fp_fwd_hazard_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int KIND_W     = 3,
    parameter int EARLY_KIND = 4
) (
    input  logic [ADDR_W-1:0] src_x_addr,
    input  logic [ADDR_W-1:0] src_y_addr,
    input  logic [ADDR_W-1:0] src_z_addr,
    input  logic              mem_wr_en,
    input  logic [ADDR_W-1:0] mem_dst_addr,
    input  logic [KIND_W-1:0] mem_res_kind,
    input  logic              wb_wr_en,
    input  logic [ADDR_W-1:0] wb_dst_addr,
    output logic [1:0]        fwd_x_sel,
    output logic [1:0]        fwd_y_sel,
    output logic [1:0]        fwd_z_sel,
    output logic              stall_dec
);
    localparam int NumSrc = 3;

    logic [NumSrc-1:0][ADDR_W-1:0] src_addr;
    fwd_sel_e                      sel   [NumSrc];
    logic [NumSrc-1:0]             mem_hit;

    // Gather the operand addresses into an indexed array.
    always_comb src_addr = {src_z_addr, src_y_addr, src_x_addr};

    // One resolver per operand (R8: independent resolution).
    for (genvar i = 0; i < NumSrc; i++) begin : g_operand
        fp_operand_fwd #(.ADDR_W(ADDR_W)) u_operand (
            .src_addr    (src_addr[i]),
            .mem_wr_en   (mem_wr_en),
            .mem_dst_addr(mem_dst_addr),
            .wb_wr_en    (wb_wr_en),
            .wb_dst_addr (wb_dst_addr),
            .sel         (sel[i]),
            .mem_hit     (mem_hit[i])
        );
    end

    fp_stall_detect #(
        .NUM_SRC   (NumSrc),
        .KIND_W    (KIND_W),
        .EARLY_KIND(EARLY_KIND)
    ) u_stall (
        .mem_hit     (mem_hit),
        .mem_res_kind(mem_res_kind),
        .stall       (stall_dec)
    );

    // Drive the plain-typed select ports.
    always_comb begin
        fwd_x_sel = sel[0];
        fwd_y_sel = sel[1];
        fwd_z_sel = sel[2];
    end

    // Cross-module check: a stall must come from an operand taking memory data.
    always_comb begin
        p_stall_has_cause_r7: assert (!stall_dec ||
            fwd_x_sel == FWD_MEM || fwd_y_sel == FWD_MEM || fwd_z_sel == FWD_MEM)
            else $error("stall without any memory-stage dependence");
        p_wb_never_stalls_r9: assert (!stall_dec || mem_wr_en)
            else $error("stall raised with memory write disabled");
    end
endmodule

// File: tb/fp_fwd_hazard_bench.sv
// Directed bench for fp_fwd_hazard; inputs change on the rising edge,
// outputs are sampled on the falling edge.
module fp_fwd_hazard_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk; // 250 MHz

    logic [4:0] sx = '0, sy = '0, sz = '0, md = '0, wd = '0;
    logic       mwe = 1'b0, wwe = 1'b0;
    logic [2:0] kind = '0;
    logic [1:0] fx, fy, fz;
    logic       stall;

    int tests = 0, fails = 0;
    bit done = 0;

    fp_fwd_hazard u_fp_fwd_hazard (
        .src_x_addr(sx), .src_y_addr(sy), .src_z_addr(sz),
        .mem_wr_en(mwe), .mem_dst_addr(md), .mem_res_kind(kind),
        .wb_wr_en(wwe), .wb_dst_addr(wd),
        .fwd_x_sel(fx), .fwd_y_sel(fy), .fwd_z_sel(fz), .stall_dec(stall)
    );

    function automatic logic [1:0] ref_sel(input logic [4:0] a);
        if (mwe && a == md)      return 2'd2;
        else if (wwe && a == wd) return 2'd1;
        else                     return 2'd0;
    endfunction

    function automatic logic ref_stall();
        return (kind != 3'd4) &&
               ((mwe && sx == md) || (mwe && sy == md) || (mwe && sz == md));
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] x, y, z, m, w,
                         input logic me, we, input logic [2:0] k);
        @(posedge clk);
        sx = x; sy = y; sz = z; md = m; wd = w; mwe = me; wwe = we; kind = k;
        @(negedge clk);
    endtask

    // Compare all outputs with the model; selects only when not stalling.
    task automatic check_all(input string req);
        check({req, " stall"}, {2'b0, stall}, {2'b0, ref_stall()});
        if (!ref_stall()) begin
            check({req, " x"}, {1'b0, fx}, {1'b0, ref_sel(sx)});
            check({req, " y"}, {1'b0, fy}, {1'b0, ref_sel(sy)});
            check({req, " z"}, {1'b0, fz}, {1'b0, ref_sel(sz)});
        end
    endtask

    task automatic t_no_match;
        apply(5'd1, 5'd2, 5'd3, 5'd9, 5'd10, 1'b1, 1'b1, 3'd0);
        check("R1 x", {1'b0, fx}, 3'd0);
        check("R1 y", {1'b0, fy}, 3'd0);
        check("R1 z", {1'b0, fz}, 3'd0);
        check("R1 stall", {2'b0, stall}, 3'd0);
    endtask

    task automatic t_mem_early;
        apply(5'd7, 5'd2, 5'd3, 5'd7, 5'd10, 1'b1, 1'b1, 3'd4);
        check("R2 x mem", {1'b0, fx}, 3'd2);
        check("R2 no stall", {2'b0, stall}, 3'd0);
    endtask

    task automatic t_wb_only;
        apply(5'd1, 5'd12, 5'd3, 5'd9, 5'd12, 1'b1, 1'b1, 3'd0);
        check("R3 y wb", {1'b0, fy}, 3'd1);
        check("R3 x rf", {1'b0, fx}, 3'd0);
    endtask

    task automatic t_priority;
        apply(5'd1, 5'd2, 5'd20, 5'd20, 5'd20, 1'b1, 1'b1, 3'd4);
        check("R4 z mem wins", {1'b0, fz}, 3'd2);
    endtask

    task automatic t_mem_disabled;
        apply(5'd5, 5'd6, 5'd3, 5'd5, 5'd6, 1'b0, 1'b1, 3'd1);
        check("R5 x rf", {1'b0, fx}, 3'd0);
        check("R5 y wb", {1'b0, fy}, 3'd1);
        check("R5 no stall", {2'b0, stall}, 3'd0);
        apply(5'd6, 5'd2, 5'd3, 5'd6, 5'd6, 1'b0, 1'b1, 3'd0);
        check("R5 x falls to wb", {1'b0, fx}, 3'd1);
    endtask

    task automatic t_wb_disabled;
        apply(5'd8, 5'd2, 5'd3, 5'd9, 5'd8, 1'b1, 1'b0, 3'd0);
        check("R6 x rf", {1'b0, fx}, 3'd0);
        check("R6 no stall", {2'b0, stall}, 3'd0);
    endtask

    task automatic t_late_stall;
        for (int k = 0; k < 8; k++) begin
            apply(5'd1, 5'd2, 5'd30, 5'd30, 5'd4, 1'b1, 1'b1, 3'(k));
            check("R7 z late stall", {2'b0, stall}, (k == 4) ? 3'd0 : 3'd1);
        end
    endtask

    task automatic t_mixed;
        apply(5'd11, 5'd12, 5'd13, 5'd11, 5'd12, 1'b1, 1'b1, 3'd4);
        check("R8 x mem", {1'b0, fx}, 3'd2);
        check("R8 y wb", {1'b0, fy}, 3'd1);
        check("R8 z rf", {1'b0, fz}, 3'd0);
    endtask

    task automatic t_wb_no_stall;
        for (int k = 0; k < 8; k++) begin
            apply(5'd15, 5'd15, 5'd15, 5'd3, 5'd15, 1'b1, 1'b1, 3'(k));
            check("R9 wb no stall", {2'b0, stall}, 3'd0);
            check("R9 x wb", {1'b0, fx}, 3'd1);
        end
    endtask

    // Sweep: every operand from {mem, wb, other} for all enables and codes.
    task automatic t_sweep;
        logic [4:0] pick [3];
        pick[0] = 5'd21; pick[1] = 5'd22; pick[2] = 5'd23;
        for (int c = 0; c < 27; c++)
            for (int e = 0; e < 4; e++)
                for (int k = 0; k < 8; k++) begin
                    apply(pick[c % 3], pick[(c / 3) % 3], pick[c / 9],
                          5'd21, 5'd22, e[0], e[1], 3'(k));
                    check_all("R8 sweep");
                    check("R10 no code3", {2'b0, (fx == 2'd3) || (fy == 2'd3) || (fz == 2'd3)}, 3'd0);
                end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check("R1 reset stall", {2'b0, stall}, 3'd0);
        t_no_match();
        t_mem_early();
        t_wb_only();
        t_priority();
        t_mem_disabled();
        t_wb_disabled();
        t_late_stall();
        t_mixed();
        t_wb_no_stall();
        t_sweep();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule